// File: doc/BRIEF.md
# SDRAM Closed-Page Command Sequencer

This block sits between a simple single-word request port and one SDRAM device with four banks. Every accepted request becomes a closed-page access: the row is opened, one read or write burst is issued to the requested column, and the bank is closed again. The block drives the four command strobes, the bank select and a shared row/column address bus. It also drives the write data with its output enable, samples the read data and hands the read beats back with a valid strobe.

All spacing between commands comes from run-time timing inputs: CAS latency, row-to-column delay, precharge time, active-to-precharge time, command rate and burst length. The values are captured when a request is accepted, so they can change freely between accesses. The active-to-precharge interval is stretched when needed so that the precharge never cuts into the burst. Only one access is in flight at a time. The ready signal rises in the final cycle of an access, so back-to-back accesses run with no dead cycle.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The strobes {cs_n, ras_n, cas_n, we_n} carry these codes: deselect 1111 when idle, NOP 0111, activate 0011, read 0101, write 0100, precharge 0010. Every cycle of an access that carries no command is NOP.
- R2: Activate starts in the cycle right after the handshake and carries the row on sd_addr. sd_ba holds the request bank for the whole access and is 0 when idle.
- R3: Read or write starts max(tRCD, CR) cycles after activate starts, with a tRCD of 0 treated as 1. It carries the column zero-extended on sd_addr.
- R4: For a read, sd_dq_in is sampled for BL consecutive cycles starting tCL cycles after the read starts, with a tCL of 0 treated as 1. Each beat appears on rd_data with rd_valid high one cycle after it is sampled.
- R5: The burst code sets BL: 00 gives 2, 01 gives 4, 10 and 11 give 8.
- R6: For a write, sd_dq_oe is high and sd_dq_out carries the request data for BL cycles starting with the write command. At all other times sd_dq_oe is 0 and sd_dq_out is 0.
- R7: Precharge starts max(tRAS, RW + tCL + BL) cycles after activate, where RW is the R3 offset. sd_addr is 0 during precharge.
- R8: The next activate starts no earlier than max(tRP, CR) cycles after precharge starts, with a tRP of 0 treated as 1. When a request is waiting, it starts exactly then.
- R9: With cfg_cmd_rate2 low, each command lasts one cycle. With it high, each command lasts two cycles.
- R10: req_ready is high only when idle or in the last cycle of an access. While req_ready is low, req_valid is ignored. Timing inputs are used only as sampled at the handshake.
- R11: A synchronous active-low reset abandons any access, forces deselect, rd_valid 0 and dq_oe 0, and holds req_ready low while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_bank | input | 2 | Bank select |
| req_row | input | 13 | Row address |
| req_col | input | 10 | Column address |
| req_wdata | input | 8 | Write data |
| cfg_tcl | input | 3 | CAS latency in cycles |
| cfg_trcd | input | 4 | Activate-to-column delay |
| cfg_trp | input | 4 | Precharge time |
| cfg_tras | input | 5 | Minimum activate-to-precharge time |
| cfg_cmd_rate2 | input | 1 | Hold each command two cycles |
| cfg_burst | input | 2 | Burst length code |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed row/column address |
| sd_dq_out | output | 8 | Write data to the device |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 8 | Read data from the device |
| rd_data | output | 8 | Returned read beat |
| rd_valid | output | 1 | rd_data holds a beat |

## Verification
The embedded assertions watch the command spacing on every cycle. They check that each column command comes at least tRCD after its activate and each precharge at least tRAS after it. They check that a new activate respects tRP after the previous precharge, that each activate follows a handshake, and that a write burst has finished before precharge. They also check that commands are held two cycles under the slower command rate and that read beats come back only for reads. Exact cycle placement needs the bench's scenarios: the stretched precharge, clamping of zero timing values, burst-code decoding, beat data ordering, config changes while busy, back-to-back accesses and a reset in the middle of an access.

// File: rtl/sdram_seq_pkg.sv
// Shared command codes and burst decode for the SDRAM sequencer.
// Assumes the strobe order {cs_n, ras_n, cas_n, we_n}.
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'b1111,
        CMD_NOP   = 4'b0111,
        CMD_ACT   = 4'b0011,
        CMD_RD    = 4'b0101,
        CMD_WR    = 4'b0100,
        CMD_PRE   = 4'b0010
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ASEL_ZERO = 2'd0,
        ASEL_ROW  = 2'd1,
        ASEL_COL  = 2'd2
    } addr_sel_e;

    // Burst code to beat count: 0->2, 1->4, 2 and 3->8.
    function automatic logic [3:0] burst_beats(input logic [1:0] code);
        case (code)
            2'd0:    burst_beats = 4'd2;
            2'd1:    burst_beats = 4'd4;
            default: burst_beats = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/sdram_timing_calc.sv
// Turns captured timing settings into cycle offsets measured from the
// first activate cycle. Assumes CNT_W holds the sum of all maxima.
module sdram_timing_calc
    import sdram_seq_pkg::*;
#(
    parameter int TCL_W  = 3,
    parameter int TRCD_W = 4,
    parameter int TRP_W  = 4,
    parameter int TRAS_W = 5,
    parameter int CNT_W  = 8
) (
    input  logic [TCL_W-1:0]  tcl,
    input  logic [TRCD_W-1:0] trcd,
    input  logic [TRP_W-1:0]  trp,
    input  logic [TRAS_W-1:0] tras,
    input  logic              cr2,
    input  logic [1:0]        burst,
    output logic [CNT_W-1:0]  t_rw,
    output logic [CNT_W-1:0]  t_pre,
    output logic [CNT_W-1:0]  t_end,
    output logic [CNT_W-1:0]  tcl_eff,
    output logic [CNT_W-1:0]  bl,
    output logic [CNT_W-1:0]  cr
);
    logic [CNT_W-1:0] rcd, rp, ras, need;

    // Clamp zero settings, apply command rate floor, stretch precharge.
    always_comb begin
        cr      = cr2 ? CNT_W'(2) : CNT_W'(1);
        tcl_eff = (tcl == '0) ? CNT_W'(1) : CNT_W'(tcl);
        rcd     = (trcd == '0) ? CNT_W'(1) : CNT_W'(trcd);
        if (rcd < cr) rcd = cr;
        bl      = CNT_W'(burst_beats(burst));
        need    = rcd + tcl_eff + bl;
        ras     = CNT_W'(tras);
        t_pre   = (ras > need) ? ras : need;
        rp      = (trp == '0) ? CNT_W'(1) : CNT_W'(trp);
        if (rp < cr) rp = cr;
        t_rw    = rcd;
        t_end   = t_pre + rp - CNT_W'(1);
    end

endmodule

// File: rtl/sdram_cmd_gen.sv
// Decodes the access cycle counter into the command on the strobes and
// the address source. Assumes t_rw >= cr and t_pre >= t_rw + cr.
module sdram_cmd_gen
    import sdram_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             busy,
    input  logic             is_write,
    input  logic [CNT_W-1:0] t,
    input  logic [CNT_W-1:0] t_rw,
    input  logic [CNT_W-1:0] t_pre,
    input  logic [CNT_W-1:0] cr,
    output sd_cmd_e          cmd,
    output addr_sel_e        asel
);
    // Pick the command whose window contains the current cycle.
    always_comb begin
        cmd  = busy ? CMD_NOP : CMD_DESEL;
        asel = ASEL_ZERO;
        if (busy) begin
            if (t < cr) begin
                cmd  = CMD_ACT;
                asel = ASEL_ROW;
            end else if (t >= t_rw && t < t_rw + cr) begin
                cmd  = is_write ? CMD_WR : CMD_RD;
                asel = ASEL_COL;
            end else if (t >= t_pre && t < t_pre + cr) begin
                cmd  = CMD_PRE;
            end
        end
    end

endmodule

// File: rtl/sdram_data_path.sv
// Drives write beats and registers read beats. Assumes the counter t
// starts at 0 on the activate cycle and that dq_in is synchronous.
module sdram_data_path #(
    parameter int CNT_W = 8,
    parameter int DQ_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             is_write,
    input  logic [CNT_W-1:0] t,
    input  logic [CNT_W-1:0] t_rw,
    input  logic [CNT_W-1:0] tcl_eff,
    input  logic [CNT_W-1:0] bl,
    input  logic [DQ_W-1:0]  wdata,
    input  logic [DQ_W-1:0]  dq_in,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_oe,
    output logic [DQ_W-1:0]  rd_data,
    output logic             rd_valid
);
    logic [CNT_W-1:0] rd_first;
    logic             rd_win;

    // Write window and read sampling window from the column command.
    always_comb begin
        rd_first = t_rw + tcl_eff;
        dq_oe    = busy && is_write && t >= t_rw && t < t_rw + bl;
        dq_out   = dq_oe ? wdata : '0;
        rd_win   = busy && !is_write && t >= rd_first && t < rd_first + bl;
    end

    // Capture one read beat per sampling cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_win;
            rd_data  <= rd_win ? dq_in : rd_data;
        end
    end

    // R4: beats only for reads, never while writing.
    a_r4_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !dq_oe);

endmodule

// File: rtl/sdram_cmd_seq.sv
// Closed-page SDRAM sequencer: one request becomes activate, read or
// write, precharge. Assumes a single device, one access at a time, and
// timing inputs stable in the handshake cycle.
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int DQ_W   = 8,
    parameter int TCL_W  = 3,
    parameter int TRCD_W = 4,
    parameter int TRP_W  = 4,
    parameter int TRAS_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [TCL_W-1:0]  cfg_tcl,
    input  logic [TRCD_W-1:0] cfg_trcd,
    input  logic [TRP_W-1:0]  cfg_trp,
    input  logic [TRAS_W-1:0] cfg_tras,
    input  logic              cfg_cmd_rate2,
    input  logic [1:0]        cfg_burst,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in,
    output logic [DQ_W-1:0]   rd_data,
    output logic              rd_valid
);
    localparam int CNT_W = $clog2((1 << TRAS_W) + (1 << TRCD_W)
                                  + (1 << TCL_W) + (1 << TRP_W) + 16) + 1;

    logic              busy, last, accept;
    logic [CNT_W-1:0]  t, t_rw, t_pre, t_end, tcl_eff, bl, cr;
    logic              l_write, l_cr2;
    logic [BANK_W-1:0] l_bank;
    logic [ROW_W-1:0]  l_row;
    logic [COL_W-1:0]  l_col;
    logic [DQ_W-1:0]   l_wdata;
    logic [TCL_W-1:0]  l_tcl;
    logic [TRCD_W-1:0] l_trcd;
    logic [TRP_W-1:0]  l_trp;
    logic [TRAS_W-1:0] l_tras;
    logic [1:0]        l_burst;
    sd_cmd_e           cmd;
    addr_sel_e         asel;

    // Handshake: free when idle or in the final cycle of an access.
    always_comb begin
        last      = busy && (t == t_end);
        req_ready = rst_n && (!busy || last);
        accept    = req_valid && req_ready;
    end

    // Access counter and snapshot of the request and its timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            t       <= '0;
            l_write <= 1'b0;
            l_cr2   <= 1'b0;
            l_bank  <= '0;
            l_row   <= '0;
            l_col   <= '0;
            l_wdata <= '0;
            l_tcl   <= '0;
            l_trcd  <= '0;
            l_trp   <= '0;
            l_tras  <= '0;
            l_burst <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            t       <= '0;
            l_write <= req_write;
            l_cr2   <= cfg_cmd_rate2;
            l_bank  <= req_bank;
            l_row   <= req_row;
            l_col   <= req_col;
            l_wdata <= req_wdata;
            l_tcl   <= cfg_tcl;
            l_trcd  <= cfg_trcd;
            l_trp   <= cfg_trp;
            l_tras  <= cfg_tras;
            l_burst <= cfg_burst;
        end else if (last) begin
            busy    <= 1'b0;
        end else if (busy) begin
            t       <= t + CNT_W'(1);
        end
    end

    sdram_timing_calc #(
        .TCL_W(TCL_W), .TRCD_W(TRCD_W), .TRP_W(TRP_W),
        .TRAS_W(TRAS_W), .CNT_W(CNT_W)
    ) u_timing (
        .tcl(l_tcl), .trcd(l_trcd), .trp(l_trp), .tras(l_tras),
        .cr2(l_cr2), .burst(l_burst),
        .t_rw(t_rw), .t_pre(t_pre), .t_end(t_end),
        .tcl_eff(tcl_eff), .bl(bl), .cr(cr)
    );

    sdram_cmd_gen #(.CNT_W(CNT_W)) u_cmd (
        .busy(busy), .is_write(l_write), .t(t), .t_rw(t_rw),
        .t_pre(t_pre), .cr(cr), .cmd(cmd), .asel(asel)
    );

    sdram_data_path #(.CNT_W(CNT_W), .DQ_W(DQ_W)) u_data (
        .clk(clk), .rst_n(rst_n), .busy(busy), .is_write(l_write),
        .t(t), .t_rw(t_rw), .tcl_eff(tcl_eff), .bl(bl),
        .wdata(l_wdata), .dq_in(sd_dq_in), .dq_out(sd_dq_out),
        .dq_oe(sd_dq_oe), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Device pins: strobes, bank and multiplexed address.
    always_comb begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
        sd_ba = busy ? l_bank : '0;
        case (asel)
            ASEL_ROW: sd_addr = l_row;
            ASEL_COL: sd_addr = ROW_W'(l_col);
            default:  sd_addr = '0;
        endcase
    end

    // ---------------- checking logic ----------------
    logic [3:0]       prev_cmd;
    logic [CNT_W:0]   since_act, since_pre;
    logic             pre_seen;
    logic             act_start, col_start, pre_start, any_start;

    // Detect the first cycle of each command.
    always_comb begin
        act_start = (cmd == CMD_ACT) && (prev_cmd != 4'(CMD_ACT));
        col_start = (cmd == CMD_RD || cmd == CMD_WR) && (prev_cmd != 4'(cmd));
        pre_start = (cmd == CMD_PRE) && (prev_cmd != 4'(CMD_PRE));
        any_start = act_start || col_start || pre_start;
    end

    // Cycles elapsed since the last activate and precharge began.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_cmd  <= 4'(CMD_DESEL);
            since_act <= '0;
            since_pre <= '0;
            pre_seen  <= 1'b0;
        end else begin
            prev_cmd  <= 4'(cmd);
            since_act <= act_start ? (CNT_W+1)'(1)
                       : (since_act == '1 ? since_act : since_act + 1'b1);
            since_pre <= pre_start ? (CNT_W+1)'(1)
                       : (since_pre == '1 ? since_pre : since_pre + 1'b1);
            pre_seen  <= pre_seen || pre_start;
        end
    end

    // R2: an activate only follows an accepted request.
    a_r2_act_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        act_start |-> $past(req_valid && req_ready));

    // R3: column command no earlier than tRCD after activate.
    a_r3_rcd_met: assert property (@(posedge clk) disable iff (!rst_n)
        col_start |-> since_act >= (CNT_W+1)'(l_trcd));

    // R7: precharge no earlier than tRAS after activate.
    a_r7_ras_met: assert property (@(posedge clk) disable iff (!rst_n)
        pre_start |-> since_act >= (CNT_W+1)'(l_tras));

    // R7: a write burst has ended before precharge.
    a_r7_wr_burst_done: assert property (@(posedge clk) disable iff (!rst_n)
        pre_start |-> !sd_dq_oe);

    // R8: activate respects the precharge time of the previous access.
    a_r8_rp_met: assert property (@(posedge clk) disable iff (!rst_n)
        (act_start && pre_seen) |-> since_pre >= (CNT_W+1)'($past(l_trp)));

    // R9: under the slow command rate a command stays for a second cycle.
    a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (any_start && l_cr2) |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == $past(4'(cmd))));

endmodule

// File: tb/sim_sdram_cmd_seq.sv
// Cycle-level reference model: each accepted request expands into a
// queue of expected per-cycle pin values compared every clock.
module sim_sdram_cmd_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [9:0]  req_col;
    logic [7:0]  req_wdata;
    logic [2:0]  cfg_tcl;
    logic [3:0]  cfg_trcd, cfg_trp;
    logic [4:0]  cfg_tras;
    logic        cfg_cmd_rate2;
    logic [1:0]  cfg_burst;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [7:0]  sd_dq_out, sd_dq_in, rd_data;
    logic        sd_dq_oe, rd_valid;

    always #5 clk = ~clk;

    sdram_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata), .cfg_tcl(cfg_tcl),
        .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
        .cfg_cmd_rate2(cfg_cmd_rate2), .cfg_burst(cfg_burst),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    typedef struct {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic        oe;
        logic [7:0]  dout;
        logic        rv;
        logic [7:0]  rd;
        string       tag;
    } exp_t;

    typedef struct {
        logic        wr;
        logic [1:0]  bank;
        logic [12:0] row;
        logic [9:0]  col;
        logic [7:0]  wd;
        int          tcl, trcd, trp, tras;
        logic        cr2;
        logic [1:0]  bc;
    } req_t;

    exp_t q[$];
    req_t rq[$];
    int   n_cmp = 0, n_bad = 0, cyc = 0;

    function automatic logic [7:0] pat(input int c);
        return 8'((c * 37 + 5) & 255);
    endfunction

    function automatic req_t mk(input logic wr, input logic [1:0] bank,
                                input logic [12:0] row, input logic [9:0] col,
                                input logic [7:0] wd, input int tcl, input int trcd,
                                input int trp, input int tras, input logic cr2,
                                input logic [1:0] bc);
        req_t r;
        r.wr = wr; r.bank = bank; r.row = row; r.col = col; r.wd = wd;
        r.tcl = tcl; r.trcd = trcd; r.trp = trp; r.tras = tras;
        r.cr2 = cr2; r.bc = bc;
        return r;
    endfunction

    // Expand one access into expected per-cycle values from the requirements.
    task automatic push_model(input req_t r, input int start);
        int cr, tc, rcd, bl, need, tp, rp;
        exp_t e;
        cr   = r.cr2 ? 2 : 1;
        tc   = (r.tcl == 0) ? 1 : r.tcl;
        rcd  = (r.trcd == 0) ? 1 : r.trcd;
        if (rcd < cr) rcd = cr;
        bl   = (r.bc == 2'd0) ? 2 : (r.bc == 2'd1) ? 4 : 8;  // R5
        need = rcd + tc + bl;
        tp   = (r.tras > need) ? r.tras : need;
        rp   = (r.trp == 0) ? 1 : r.trp;
        if (rp < cr) rp = cr;
        for (int k = 0; k < tp + rp; k++) begin
            e.cmd = 4'b0111; e.addr = '0; e.tag = "R1"; e.ba = r.bank;
            if (k < cr) begin
                e.cmd = 4'b0011; e.addr = r.row; e.tag = "R2";
            end else if (k >= rcd && k < rcd + cr) begin
                e.cmd = r.wr ? 4'b0100 : 4'b0101; e.addr = 13'(r.col); e.tag = "R3";
            end else if (k >= tp && k < tp + cr) begin
                e.cmd = 4'b0010; e.tag = "R7";
            end
            e.oe   = r.wr && k >= rcd && k < rcd + bl;
            e.dout = e.oe ? r.wd : 8'h00;
            e.rv   = !r.wr && (k - 1) >= rcd + tc && (k - 1) < rcd + tc + bl;
            e.rd   = pat(start + k - 1);
            q.push_back(e);
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One clock: compare this cycle against the model, then drive inputs.
    task automatic step;
        exp_t e;
        logic [3:0] pins;
        bit exp_rdy;
        @(negedge clk);
        cyc++;
        if (cyc > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 20000);
            summary();
        end
        exp_rdy = rst_n && (q.size() <= 1);
        if (q.size() > 0) e = q.pop_front();
        else begin
            e.cmd = 4'b1111; e.ba = '0; e.addr = '0; e.oe = 0; e.dout = '0;
            e.rv = 0; e.rd = '0; e.tag = rst_n ? "R1" : "R11";
        end
        pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        chk(pins === e.cmd, e.tag, "cmd", 32'(pins), 32'(e.cmd));
        chk(sd_addr === e.addr, e.tag, "addr", 32'(sd_addr), 32'(e.addr));
        chk(sd_ba === e.ba, "R2", "bank", 32'(sd_ba), 32'(e.ba));
        chk(sd_dq_oe === e.oe, "R6", "dq_oe", 32'(sd_dq_oe), 32'(e.oe));
        chk(sd_dq_out === e.dout, "R6", "dq_out", 32'(sd_dq_out), 32'(e.dout));
        chk(rd_valid === e.rv, "R4", "rd_valid", 32'(rd_valid), 32'(e.rv));
        if (e.rv) chk(rd_data === e.rd, "R4", "rd_data", 32'(rd_data), 32'(e.rd));
        chk(req_ready === exp_rdy, rst_n ? "R10" : "R11", "ready",
            32'(req_ready), 32'(exp_rdy));
        sd_dq_in = pat(cyc);
        if (rq.size() > 0) begin
            req_valid = 1'b1;
            req_write = rq[0].wr;  req_bank = rq[0].bank;
            req_row = rq[0].row;   req_col = rq[0].col;  req_wdata = rq[0].wd;
            cfg_tcl = 3'(rq[0].tcl);   cfg_trcd = 4'(rq[0].trcd);
            cfg_trp = 4'(rq[0].trp);   cfg_tras = 5'(rq[0].tras);
            cfg_cmd_rate2 = rq[0].cr2; cfg_burst = rq[0].bc;
            if (req_ready) begin
                push_model(rq[0], cyc + 1);
                void'(rq.pop_front());
            end
        end else begin
            req_valid = 1'b0;
        end
    endtask

    task automatic drain;
        while (rq.size() > 0 || q.size() > 0) step();
        step();
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 0; req_write = 0; req_bank = 0; req_row = 0;
        req_col = 0; req_wdata = 0; cfg_tcl = 2; cfg_trcd = 3; cfg_trp = 4;
        cfg_tras = 5; cfg_cmd_rate2 = 0; cfg_burst = 0; sd_dq_in = 0;
        repeat (3) step();   // R11: reset state, deselect, not ready
        rst_n = 1'b1;
        step();
        // R5 R7: default timing, BL2, precharge stretched past tRAS=5
        rq.push_back(mk(0, 2'd0, 13'h1234, 10'h3FF, 8'h00, 2, 3, 4, 5, 0, 2'd0));
        // R6: write BL4 to bank 3
        rq.push_back(mk(1, 2'd3, 13'h0000, 10'h001, 8'hA5, 2, 3, 4, 5, 0, 2'd1));
        // R9: command rate 2, tRAS dominates, read BL8
        rq.push_back(mk(0, 2'd2, 13'h1FFF, 10'h155, 8'h00, 3, 2, 2, 20, 1, 2'd2));
        // R3 R4 R8: zero settings are clamped, read BL4
        rq.push_back(mk(0, 2'd1, 13'h0AAA, 10'h2AA, 8'h00, 0, 0, 0, 0, 0, 2'd1));
        // R9 R3: cr2 raises tRCD and tRP of 1 to 2, write BL8
        rq.push_back(mk(1, 2'd1, 13'h0F0F, 10'h0F0, 8'h3C, 1, 1, 1, 3, 1, 2'd2));
        // R5: burst code 3 behaves as 8
        rq.push_back(mk(0, 2'd3, 13'h0001, 10'h3C3, 8'h00, 4, 5, 6, 9, 0, 2'd3));
        // R10: back-to-back writes, valid held while busy, config changes
        rq.push_back(mk(1, 2'd0, 13'h0100, 10'h010, 8'h11, 2, 3, 4, 5, 0, 2'd0));
        rq.push_back(mk(1, 2'd2, 13'h0200, 10'h020, 8'h22, 7, 15, 15, 31, 1, 2'd2));
        rq.push_back(mk(0, 2'd1, 13'h0300, 10'h030, 8'h00, 1, 1, 1, 1, 0, 2'd0));
        drain();
        // R11: reset in the middle of a read abandons it
        rq.push_back(mk(0, 2'd2, 13'h0555, 10'h055, 8'h00, 2, 3, 4, 20, 0, 2'd2));
        while (q.size() == 0) step();
        repeat (6) step();
        rst_n = 1'b0;
        q.delete();
        repeat (3) step();
        rst_n = 1'b1;
        rq.push_back(mk(1, 2'd3, 13'h1ABC, 10'h0CD, 8'h5A, 2, 3, 4, 5, 0, 2'd1));
        drain();
        summary();
    end

endmodule